// File: doc/BRIEF.md
# Two-Channel Compare-Match Interval Timer

This block holds two independent 16-bit up-counters, each fed by its own prescaler that divides the block clock by 8, 32, 128 or 512. While a channel runs, its counter steps once per prescaled tick. When the counter equals the channel's compare value on a tick, the counter returns to zero and keeps counting. If that channel's interrupt enable is set, it also raises a one-cycle interrupt pulse. The interval is therefore (compare + 1) prescaled ticks.

Software reaches the block through a plain 16-bit register port with a word address, a write enable and a combinational read-data bus. There is one shared run register, and each channel has a control word, its live counter and its compare value. Writes to the counter or the compare value take effect on the next clock edge, even while the channel runs.

Top module: `dual_match_timer`

## Requirements
- R1: After reset, the run register, both control words and both counters read 0x0000, and both compare values read 0xFFFF.
- R2: Bit 0 of the run register (word 0) runs channel 0 and bit 1 runs channel 1. A stopped channel keeps its counter value and raises no interrupt, even when the counter equals the compare value.
- R3: Control bits 1:0 choose the divide ratio: code 0 gives /8, 1 gives /32, 2 gives /128 and 3 gives /512. The prescaler starts again from zero each time its channel is started, so the first counter increment lands exactly N clock edges after the edge that wrote the run bit.
- R4: Control bit 6 enables the channel's interrupt. With it clear, the counter still clears on a match but no pulse is raised.
- R5: On a tick where the counter equals the compare value, the counter becomes 0 and, when enabled, the interrupt is high for exactly the one cycle that follows that edge. Successive pulses are (compare + 1) × N cycles apart.
- R6: A counter or compare write to a running channel takes effect at the write edge. A counter above the compare value counts through 0xFFFF, wraps to 0 and then matches.
- R7: If a counter write lands on the same edge as a match, the written value is kept and no interrupt pulse is raised for that match.
- R8: Reading word 0 returns the run bits in bits 1:0 with all other bits zero. A control word reads back only bits 1:0 and 6. An undefined word reads 0xFFFF.
- R9: Word addresses, each at byte offset twice the word: 0 is run, 1/2/3 are channel 0 control/counter/compare, 4/5/6 are channel 1 control/counter/compare, and 7 is undefined.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock, also the prescaler source |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one write per cycle it is high |
| addr_i | input | 3 | Word address of the access |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| irq_o | output | 2 | Per-channel compare-match interrupt pulse |

## Verification
The properties assume that addr_i and wr_en_i are stable through each clock cycle, and that a write to the counter word counts as a software update rather than a tick. The single-cycle pulse property depends on the shortest possible interval being eight cycles, which holds because the smallest divide ratio is 8. The stimulus changes inputs only at falling edges and drives one write per cycle. It places a counter write on an exact match edge only when it checks the collision rule on purpose.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  localparam int unsigned DMT_CKS_W         = 2;
  localparam int unsigned DMT_IE_BIT        = 6;
  localparam int unsigned DMT_REGS_PER_CH   = 3;
  localparam int unsigned DMT_OFS_CTL       = 0;
  localparam int unsigned DMT_OFS_CNT       = 1;
  localparam int unsigned DMT_OFS_CMP       = 2;
  localparam int unsigned DMT_DIV_BASE_LOG2 = 3;
  localparam int unsigned DMT_DIV_STEP_LOG2 = 2;

  typedef struct packed {
    logic                 ie;
    logic [DMT_CKS_W-1:0] cks;
  } dmt_ctl_t;
endpackage

// File: rtl/dmt_prescaler.sv
module dmt_prescaler
  import dmt_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = DMT_DIV_BASE_LOG2,
  parameter int unsigned STEP_LOG2 = DMT_DIV_STEP_LOG2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 run_i,
  input  logic [DMT_CKS_W-1:0] cks_i,
  output logic                 tick_o
);
  localparam int unsigned NUM_SEL = 1 << DMT_CKS_W;
  localparam int unsigned PW      = BASE_LOG2 + STEP_LOG2 * (NUM_SEL - 1);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] limit;

  always_comb begin
    limit = '0;
    for (int k = 0; k < NUM_SEL; k++) begin
      if (cks_i == DMT_CKS_W'(k)) limit = PW'((32'd1 << (BASE_LOG2 + STEP_LOG2 * k)) - 32'd1);
    end
  end

  // >= keeps a shortened ratio from running the full width
  assign tick_o = run_i && (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + PW'(1);
  end
endmodule

// File: rtl/dmt_channel.sv
module dmt_channel
  import dmt_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned BASE_LOG2 = DMT_DIV_BASE_LOG2,
  parameter int unsigned STEP_LOG2 = DMT_DIV_STEP_LOG2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              wr_ctl_i,
  input  logic              wr_cnt_i,
  input  logic              wr_cmp_i,
  input  logic [DATA_W-1:0] wdata_i,
  output dmt_ctl_t          ctl_o,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] cmp_o,
  output logic              irq_o
);
  dmt_ctl_t          ctl_q;
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] cmp_q;
  logic              irq_q;
  logic              tick;
  logic              match;

  dmt_prescaler #(
    .BASE_LOG2(BASE_LOG2),
    .STEP_LOG2(STEP_LOG2)
  ) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run_i),
    .cks_i (ctl_q.cks),
    .tick_o(tick)
  );

  assign match = tick && (cnt_q == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      cnt_q <= '0;
      cmp_q <= '1;
      irq_q <= 1'b0;
    end else begin
      // software counter write overrides the match event
      irq_q <= match && ctl_q.ie && !wr_cnt_i;
      if (wr_ctl_i) begin
        ctl_q.ie  <= wdata_i[DMT_IE_BIT];
        ctl_q.cks <= wdata_i[DMT_CKS_W-1:0];
      end
      if (wr_cmp_i)   cmp_q <= wdata_i;
      if (wr_cnt_i)   cnt_q <= wdata_i;
      else if (match) cnt_q <= '0;
      else if (tick)  cnt_q <= cnt_q + DATA_W'(1);
    end
  end

  assign ctl_o = ctl_q;
  assign cnt_o = cnt_q;
  assign cmp_o = cmp_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
  import dmt_pkg::*;
#(
  parameter int unsigned NUM_CH    = 2,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned BASE_LOG2 = DMT_DIV_BASE_LOG2,
  parameter int unsigned STEP_LOG2 = DMT_DIV_STEP_LOG2,
  parameter int unsigned ADDR_W    = $clog2(DMT_REGS_PER_CH * NUM_CH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0]             start_q;
  dmt_ctl_t                      ctl_w [NUM_CH];
  logic [NUM_CH-1:0]             ie_w;
  logic [NUM_CH-1:0][DATA_W-1:0] cnt_w;
  logic [NUM_CH-1:0][DATA_W-1:0] cmp_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         start_q <= '0;
    else if (wr_en_i && addr_i == '0)    start_q <= wdata_i[NUM_CH-1:0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned BASE = 1 + DMT_REGS_PER_CH * c;
    logic wr_ctl, wr_cnt, wr_cmp;
    assign wr_ctl = wr_en_i && (addr_i == ADDR_W'(BASE + DMT_OFS_CTL));
    assign wr_cnt = wr_en_i && (addr_i == ADDR_W'(BASE + DMT_OFS_CNT));
    assign wr_cmp = wr_en_i && (addr_i == ADDR_W'(BASE + DMT_OFS_CMP));

    dmt_channel #(
      .DATA_W   (DATA_W),
      .BASE_LOG2(BASE_LOG2),
      .STEP_LOG2(STEP_LOG2)
    ) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (start_q[c]),
      .wr_ctl_i(wr_ctl),
      .wr_cnt_i(wr_cnt),
      .wr_cmp_i(wr_cmp),
      .wdata_i (wdata_i),
      .ctl_o   (ctl_w[c]),
      .cnt_o   (cnt_w[c]),
      .cmp_o   (cmp_w[c]),
      .irq_o   (irq_o[c])
    );
    assign ie_w[c] = ctl_w[c].ie;
  end

  always_comb begin
    rdata_o = '1;
    if (addr_i == '0) rdata_o = DATA_W'(start_q);
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == ADDR_W'(1 + DMT_REGS_PER_CH * c + DMT_OFS_CTL)) begin
        rdata_o                  = '0;
        rdata_o[DMT_IE_BIT]      = ctl_w[c].ie;
        rdata_o[DMT_CKS_W-1:0]   = ctl_w[c].cks;
      end
      if (addr_i == ADDR_W'(1 + DMT_REGS_PER_CH * c + DMT_OFS_CNT)) rdata_o = cnt_w[c];
      if (addr_i == ADDR_W'(1 + DMT_REGS_PER_CH * c + DMT_OFS_CMP)) rdata_o = cmp_w[c];
    end
  end
endmodule

// File: rtl/dmt_checker.sv
module dmt_checker #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 3
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             wr_en_i,
  input logic [ADDR_W-1:0]                addr_i,
  input logic [DATA_W-1:0]                rdata_i,
  input logic [NUM_CH-1:0]                irq_i,
  input logic [NUM_CH-1:0]                start_i,
  input logic [NUM_CH-1:0]                ie_i,
  input logic [NUM_CH-1:0][DATA_W-1:0]    cnt_i
);
  AST_RUN_RD_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == '0) |-> (rdata_i[DATA_W-1:NUM_CH] == '0)); // R8

  AST_UNDEF_RD_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i > ADDR_W'(3 * NUM_CH)) |-> (rdata_i == '1)); // R8

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i[c] |=> !irq_i[c]); // R5

    AST_IRQ_CNT_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i[c] |-> (cnt_i[c] == '0)); // R5

    AST_IRQ_NEEDS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i[c] |-> $past(ie_i[c])); // R4

    AST_STOPPED_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!start_i[c] && $past(!start_i[c])) |-> !irq_i[c]); // R2

    AST_STOPPED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!start_i[c] && !(wr_en_i && addr_i == ADDR_W'(2 + 3 * c))) |=> $stable(cnt_i[c])); // R2
  end
endmodule

bind dual_match_timer dmt_checker #(
  .NUM_CH(NUM_CH),
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_en_i(wr_en_i),
  .addr_i (addr_i),
  .rdata_i(rdata_o),
  .irq_i  (irq_o),
  .start_i(start_q),
  .ie_i   (ie_w),
  .cnt_i  (cnt_w)
);

// File: tb/dual_match_timer_tb_top.sv
module dual_match_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  irq;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;
  int exp_q0[$];
  int exp_q1[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_match_timer dut_i (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .wr_en_i(wr_en),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .irq_o  (irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h (cycle %0d)", req, got, exp, cyc);
    end
  endtask

  // caller sits at a falling edge
  task automatic wr_core(input logic [2:0] a, input logic [15:0] d, output int edge_c);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    edge_c = cyc;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, output int edge_c);
    @(negedge clk);
    wr_core(a, d, edge_c);
  endtask

  task automatic wr_at(input int e, input logic [2:0] a, input logic [15:0] d, output int edge_c);
    do @(negedge clk); while (cyc < e - 1);
    wr_core(a, d, edge_c);
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, {16'h0, rdata}, {16'h0, exp});
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic drain_chk(input string req);
    chk({req, " ch0 pending"}, exp_q0.size(), 0);
    chk({req, " ch1 pending"}, exp_q1.size(), 0);
    exp_q0.delete();
    exp_q1.delete();
  endtask

  // monitor: each pulse must match the next expected cycle
  always @(negedge clk) begin
    int e;
    if (rst_n && !done) begin
      for (int ch = 0; ch < 2; ch++) begin
        if (irq[ch]) begin
          n_checks++;
          if ((ch == 0 && exp_q0.size() == 0) || (ch == 1 && exp_q1.size() == 0)) begin
            n_fail++;
            $display("FAIL R5 ch%0d: got pulse at cycle %0d expected none (R2/R4/R7)", ch, cyc);
          end else begin
            e = (ch == 0) ? exp_q0.pop_front() : exp_q1.pop_front();
            if (e != cyc) begin
              n_fail++;
              $display("FAIL R5 ch%0d: got pulse at cycle %0d expected %0d", ch, cyc, e);
            end
          end
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int n0, e, ew, t1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R9 reset values by word address
    rd_chk(3'd0, 16'h0000, "R1 run");
    rd_chk(3'd1, 16'h0000, "R1 ctl0");
    rd_chk(3'd2, 16'h0000, "R1 cnt0");
    rd_chk(3'd3, 16'hFFFF, "R1 cmp0");
    rd_chk(3'd4, 16'h0000, "R1 ctl1");
    rd_chk(3'd5, 16'h0000, "R1 cnt1");
    rd_chk(3'd6, 16'hFFFF, "R1 cmp1");
    rd_chk(3'd7, 16'hFFFF, "R8 undefined word");

    // R8 read formats
    wr(3'd4, 16'hFFFF, e);
    rd_chk(3'd4, 16'h0043, "R8 ctl1 mask");
    wr(3'd1, 16'h00BE, e);
    rd_chk(3'd1, 16'h0002, "R8 ctl0 mask");
    wr(3'd0, 16'hFFFC, e);
    rd_chk(3'd0, 16'h0000, "R8 run mask");
    wr(3'd7, 16'h1234, e);
    rd_chk(3'd7, 16'hFFFF, "R9 undefined write");

    // R2 stopped channel holds, no pulse even at equality
    wr(3'd1, 16'h0040, e);
    wr(3'd3, 16'h0005, e);
    wr(3'd2, 16'h0005, e);
    wait_cyc(e + 100);
    rd_chk(3'd2, 16'h0005, "R2 hold");
    drain_chk("R2");

    // R3/R4/R5: /8 cmp 2 on ch0, /32 cmp 1 on ch1
    wr(3'd3, 16'd2, e);   wr(3'd2, 16'd0, e);
    wr(3'd4, 16'h0041, e); wr(3'd6, 16'd1, e); wr(3'd5, 16'd0, e);
    wr(3'd0, 16'h0003, n0);
    for (int j = 1; j <= 5; j++) exp_q0.push_back(n0 + 24 * j);
    for (int j = 1; j <= 2; j++) exp_q1.push_back(n0 + 64 * j);
    wait_cyc(n0 + 6);
    rd_chk(3'd2, 16'd0, "R3 before first tick");
    rd_chk(3'd2, 16'd1, "R3 first tick at 8");
    wait_cyc(n0 + 19);
    rd_chk(3'd2, 16'd2, "R3 count at 20");
    wait_cyc(n0 + 140);
    wr(3'd0, 16'h0000, e);
    wait_cyc(e + 20);
    drain_chk("R5 /8 /32");

    // R3 restart with /512 and /128, compare 0
    wr(3'd2, 16'd0, e); wr(3'd5, 16'd0, e);
    wr(3'd1, 16'h0043, e); wr(3'd3, 16'd0, e);
    wr(3'd4, 16'h0042, e); wr(3'd6, 16'd0, e);
    wr(3'd0, 16'h0003, n0);
    for (int j = 1; j <= 2; j++) exp_q0.push_back(n0 + 512 * j);
    for (int j = 1; j <= 8; j++) exp_q1.push_back(n0 + 128 * j);
    wait_cyc(n0 + 1100);
    wr(3'd0, 16'h0000, e);
    wait_cyc(e + 20);
    drain_chk("R3 /128 /512");

    // R4 interrupt disabled: counter still clears
    wr(3'd4, 16'h0000, e); wr(3'd6, 16'd3, e); wr(3'd5, 16'd0, e);
    wr(3'd0, 16'h0002, n0);
    wait_cyc(n0 + 35);
    rd_chk(3'd5, 16'd0, "R4 cleared without pulse");
    wait_cyc(n0 + 43);
    rd_chk(3'd5, 16'd1, "R4 counting on");
    wr(3'd0, 16'h0000, e);
    wait_cyc(e + 10);
    drain_chk("R4");

    // R6 writes to a running channel, wrap through 0xFFFF
    wr(3'd1, 16'h0040, e); wr(3'd3, 16'hFFFF, e); wr(3'd2, 16'd0, e);
    wr(3'd0, 16'h0001, n0);
    wait_cyc(n0 + 18);
    wr(3'd2, 16'h0100, ew);
    rd_chk(3'd2, 16'h0100, "R6 counter write immediate");
    wr(3'd3, 16'h0102, e);
    t1 = n0 + 8 * ((ew - n0) / 8 + 1);
    exp_q0.push_back(t1 + 16);
    wait_cyc(t1 + 18);
    wr(3'd2, 16'hFFFE, ew);
    wr(3'd3, 16'h0005, e);
    rd_chk(3'd3, 16'h0005, "R6 compare write immediate");
    t1 = n0 + 8 * ((ew - n0) / 8 + 1);
    exp_q0.push_back(t1 + 56);
    wait_cyc(t1 + 9);
    rd_chk(3'd2, 16'h0000, "R6 wrapped to zero");
    wait_cyc(t1 + 60);
    wr(3'd0, 16'h0000, e);
    wait_cyc(e + 10);
    drain_chk("R6");

    // R7 counter write on the match edge wins
    wr(3'd3, 16'd2, e); wr(3'd2, 16'd0, e);
    wr(3'd0, 16'h0001, n0);
    wr_at(n0 + 24, 3'd2, 16'h0007, e);
    chk("R7 write edge", e, n0 + 24);
    rd_chk(3'd2, 16'h0007, "R7 written value kept");
    wr(3'd0, 16'h0000, e);
    wait_cyc(e + 10);
    drain_chk("R7");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule